// File: doc/BRIEF.md
# Strobe-Handshake Register Bus Slave with Address Auto-Increment

This block lets an external processor with an asynchronous, strobe-based bus reach a byte-wide register file of 4096 locations. A slow master drives chip select, an address strobe, a data strobe and a read/write select, and the block answers each transfer with an active-low acknowledge. All bus inputs are resynchronised into the system clock, and the strobe edges are detected there.

The master opens an access by holding the address strobe low while it presents the 12-bit address. It then raises the strobe, and that rising edge captures the address. Each data-strobe pulse after that moves one byte. After every completed pulse the block advances its internal address by one, so the master can run a burst of reads or writes without a new address phase. The burst ends when the address strobe goes low again. A single access is simply a burst of length one.

The controller has three states. IDLE waits for an address capture. READY holds a latched address and waits for a data strobe. XFER performs one transfer and drives the acknowledge. The transitions are: IDLE to READY on a captured address (address strobe rising with chip select low). READY to IDLE when the address strobe is low. READY to XFER when the data strobe is low with chip select low. XFER to READY when the data strobe is high and the address strobe is still high, with the address incremented. XFER to IDLE when the data strobe is high and the address strobe is low, also with the address incremented.

Top module: `mbus_burst_slave`

## Requirements
- R1: After reset the acknowledge output `dtack_n` is high (inactive), `d_oe` is low and the controller is in IDLE.
- R2: A low-to-high transition of `as_n` seen while `cs_n` is low captures `addr` into the internal address register.
- R3: `dtack_n` goes low exactly 3 clock cycles after `ds_n` falls: two synchroniser stages plus one state register. It returns high exactly 3 cycles after `ds_n` rises.
- R4: A transfer with `rw` low stores `d_in` into the byte at the current internal address.
- R5: While `dtack_n` is low on a read (`rw` high), `d_out` carries the byte at the current internal address. `d_oe` is high only while `cs_n` is low, `rw` is high and `ds_n` is low.
- R6: After each completed data strobe the internal address advances by one, so the transfers of a burst use the offsets start, start+1, start+2 and so on.
- R7: The internal address wraps from 0xFFF to 0x000.
- R8: A low level on `as_n` ends the burst. The address register then holds until a new capture, and the next access uses the newly captured address rather than continuing the old sequence.
- R9: With `cs_n` high, no address is captured, no acknowledge is given, no byte is written and `d_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe; rising edge captures the address |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 12 | Bus address |
| d_in | input | 8 | Data from the bus (write data) |
| d_out | output | 8 | Data to the bus (read data) |
| d_oe | output | 1 | Output enable for the bidirectional data pins |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The main function is exercised by a table of write bursts, each read back by a fresh burst from the same start. The table holds a three-byte run, a five-byte run in the middle of the space, a four-byte run that crosses 0xFFF to 0x000, and a single-byte access at offset zero. Distinct data seeds per run show whether the address advanced by exactly one per strobe, and the crossing run separates a correct wrap from a carry into unused bits. Directed cases then re-open a single read in the middle of an earlier run to show the burst did not continue. They also drop chip select during the address phase and during a data phase, to show that neither a capture, an acknowledge, a write nor a drive of the bus takes place.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_XFER  = 2'd2
    } bus_state_t;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
    parameter int AW = 12,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          as_s,
    input  logic          ds_s,
    input  logic          rw_s,
    input  logic [AW-1:0] addr_s,
    output bus_state_t    state_o,
    output logic [AW-1:0] addr_o,
    output logic          wr_en_o,
    output logic          dtack_n_o
);

    bus_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          as_d;
    logic          as_rise;
    logic          capture;
    logic          advance;

    assign as_rise = as_s & ~as_d;
    assign capture = (state_q == ST_IDLE) && as_rise && !cs_s;
    assign advance = (state_q == ST_XFER) && ds_s;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (capture) state_d = ST_READY;
            end
            ST_READY: begin
                if (!as_s)                  state_d = ST_IDLE;
                else if (!cs_s && !ds_s)    state_d = ST_XFER;
            end
            ST_XFER: begin
                if (ds_s) state_d = as_s ? ST_READY : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state, edge history and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            as_d    <= 1'b1;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            as_d    <= as_s;
            if (capture) begin
                addr_q <= addr_s;
            end else if (advance) begin
                addr_q <= addr_q + AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        dtack_n_o = 1'b1;
        wr_en_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READY: wr_en_o = (state_d == ST_XFER) && !rw_s;
            ST_XFER:  dtack_n_o = 1'b0;
            default:  ;
        endcase
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;

endmodule

// File: rtl/mbus_burst_slave.sv
module mbus_burst_slave
    import mbus_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic              dtack_n
);

    localparam int BUS_W = ADDR_W + DATA_W;

    logic [3:0]        ctl_s;
    logic              cs_s, as_s, ds_s, rw_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    bus_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_en;

    mbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, as_n, ds_n, rw}),
        .q     (ctl_s)
    );

    mbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, d_in}),
        .q     (bus_s)
    );

    assign {cs_s, as_s, ds_s, rw_s} = ctl_s;
    assign {addr_s, data_s}         = bus_s;

    mbus_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .as_s      (as_s),
        .ds_s      (ds_s),
        .rw_s      (rw_s),
        .addr_s    (addr_s),
        .state_o   (state_q),
        .addr_o    (addr_q),
        .wr_en_o   (wr_en),
        .dtack_n_o (dtack_n)
    );

    mbus_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk   (clk),
        .we    (wr_en),
        .waddr (addr_q),
        .wdata (data_s),
        .raddr (addr_q),
        .rdata (d_out)
    );

    assign d_oe = !cs_n && rw && !ds_n;

endmodule

// File: rtl/mbus_burst_chk.sv
module mbus_burst_chk
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_t        state,
    input logic [ADDR_W-1:0] addr_q,
    input logic [ADDR_W-1:0] addr_s,
    input logic              cs_s,
    input logic              as_s,
    input logic              ds_s,
    input logic              dtack_n
);

    // R3: acknowledge only follows a data strobe seen low one cycle earlier
    p_ack_after_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !$past(ds_s));

    // R3: acknowledge released one cycle after the strobe is seen high
    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_s) |=> dtack_n);

    // R6: completed strobe advances the address by one
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_s) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    // R7: top address wraps to zero
    p_addr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_s && addr_q == '1) |=> addr_q == '0);

    // R2: capture of the bus address on strobe rise
    p_addr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $rose(as_s) && !cs_s) |=> addr_q == $past(addr_s));

    // R8: address holds outside a transfer and a capture
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_XFER && !(state == ST_IDLE && $rose(as_s))) |=> $stable(addr_q));

    // R9: deselected chip never enters a transfer
    p_no_xfer_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && cs_s) |=> state != ST_XFER);

endmodule

bind mbus_burst_slave mbus_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .addr_q  (addr_q),
    .addr_s  (addr_s),
    .cs_s    (cs_s),
    .as_s    (as_s),
    .ds_s    (ds_s),
    .dtack_n (dtack_n)
);

// File: tb/tb_mbus_burst_slave.sv
`timescale 1ns/1ps
module tb_mbus_burst_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  d_in = '0;
    logic [7:0]  d_out;
    logic        d_oe;
    logic        dtack_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    mbus_burst_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n),
        .rw(rw), .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .dtack_n(dtack_n)
    );

    // fields: start[27:16] length[15:8] data seed[7:0]
    localparam logic [27:0] VEC [4] = '{
        {12'h100, 8'd3, 8'h10},
        {12'h7F0, 8'd5, 8'hC0},
        {12'hFFE, 8'd4, 8'h70},
        {12'h000, 8'd1, 8'hEE}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [11:0] a, input logic sel_n);
        @(negedge clk);
        as_n = 1'b0; cs_n = sel_n; addr = a;
        cyc(3);
        as_n = 1'b1;
        cyc(4);
    endtask

    task automatic end_burst();
        @(negedge clk);
        as_n = 1'b0;
        cyc(4);
        cs_n = 1'b1;
        cyc(1);
    endtask

    // one strobe; returns acknowledge latency and captured read byte
    task automatic strobe(input logic is_rd, input logic [7:0] wd,
                          output int lat, output logic [7:0] rd, output logic oe);
        int n;
        rw = is_rd; d_in = wd;
        @(negedge clk);
        ds_n = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (dtack_n && n < 20);
        lat = n; rd = d_out; oe = d_oe;
        ds_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!dtack_n && n < 20);
        check("R3 release latency", n, 3);
        cyc(2);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] rd;
        logic oe;

        cyc(5);
        check("R1 dtack idle in reset", dtack_n, 1);
        rst_n = 1'b1;
        cyc(3);
        check("R1 dtack idle after reset", dtack_n, 1);
        check("R1 d_oe low after reset", d_oe, 0);

        // table: write burst, then read back burst (R2 R4 R5 R6 R7)
        foreach (VEC[v]) begin
            logic [11:0] st;
            int          len;
            logic [7:0]  sd;
            st = VEC[v][27:16]; len = int'(VEC[v][15:8]); sd = VEC[v][7:0];
            addr_phase(st, 1'b0);
            for (int i = 0; i < len; i++) begin
                strobe(1'b0, sd + 8'(i), lat, rd, oe);
                check("R3 ack latency write", lat, 3);
                check("R5 no drive on write", oe, 0);
            end
            end_burst();
            addr_phase(st, 1'b0);
            for (int i = 0; i < len; i++) begin
                strobe(1'b1, 8'h00, lat, rd, oe);
                check("R3 ack latency read", lat, 3);
                check("R5 drive on read", oe, 1);
                check((st + 12'(i) < st) ? "R7 wrapped read" : "R6 burst read R4",
                      rd, sd + 8'(i));
            end
            check("R5 released after strobe", d_oe, 0);
            end_burst();
        end

        // R8: new single access at middle of earlier run, no continuation
        addr_phase(12'h101, 1'b0);
        strobe(1'b1, 8'h00, lat, rd, oe);
        check("R8 fresh address read", rd, 8'h11);
        end_burst();
        addr_phase(12'h102, 1'b0);
        strobe(1'b1, 8'h00, lat, rd, oe);
        check("R8 second fresh read", rd, 8'h12);
        end_burst();

        // R9: address phase with chip deselected, then a write strobe
        addr_phase(12'h7F2, 1'b1);
        rw = 1'b0; d_in = 8'h55;
        @(negedge clk); ds_n = 1'b0;
        begin
            int lows = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!dtack_n) lows++;
            end
            check("R9 no ack when deselected", lows, 0);
        end
        ds_n = 1'b1;
        cyc(3);
        as_n = 1'b0; cyc(4);

        // R9: deselect during data phase of a valid burst
        addr_phase(12'h7F2, 1'b0);
        cs_n = 1'b1; rw = 1'b1;
        @(negedge clk); ds_n = 1'b0;
        cyc(6);
        check("R9 no ack with cs high", dtack_n, 1);
        check("R9 no drive with cs high", d_oe, 0);
        ds_n = 1'b1;
        cyc(3);
        cs_n = 1'b0;
        cyc(3);
        strobe(1'b1, 8'h00, lat, rd, oe);
        check("R9 byte unchanged, address not advanced", rd, 8'hC2);
        strobe(1'b1, 8'h00, lat, rd, oe);
        check("R6 advance after deselected pulse", rd, 8'hC3);
        end_burst();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule